// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the state of a bank of interrupt sources and turns their activity into presentation requests for a downstream presentation controller. Each source is either message-type, where a rising edge on its input is one event, or level-type, where the input level is tracked continuously. Each source also has a destination server number, a current priority and a saved priority. The priority value 0xFF means the source is masked.

The presentation controller sends back three kinds of notification: reject, end-of-interrupt and a request to resend. Each source keeps four status flags: asserted, sent, rejected and masked-pending. These flags decide when a source is offered again. Level sources and message sources follow different rules for this.

Software uses a one-cycle command port to program and read each source, and to switch a source off or on. Switching a source off keeps its priority so that switching it on can restore it. Source numbers are global: source `i` appears as number `SRC_BASE + i`. A command that names a number outside the window is refused with an error.

Top module: `irq_source_ctl`

## Requirements
- R1: After reset every source reads back server 0, priority 0xFF and message type, no source is offered, and all status flags are clear.
- R2: A command op 0 (write) stores the server and priority (and the saved priority). A command op 1 (read) returns the server, the priority and the type (`rsp_level` 1 means level) on the response one cycle after the command, and changes nothing.
- R3: A command whose source number lies outside [SRC_BASE, SRC_BASE+NUM_SRC) returns `rsp_err`=1 and changes nothing. The same applies to a write whose server is NUM_SERVERS or more, or whose 9-bit priority is above 0xFF.
- R4: A rising edge on the input of an unmasked message source offers that source's global number, server and priority on the presentation port.
- R5: A rising edge on a masked message source sets masked-pending and offers nothing. A later write, or a switch-on, that unmasks the source clears masked-pending and offers the source once. A masked source is never offered.
- R6: A level source is offered when it is unmasked, its input is high and its sent flag is clear. It is evaluated when its input changes, when it is written, switched off or on, or when a resend is requested. Acceptance sets sent, and a sent source is not offered again.
- R7: A reject for a source sets its rejected flag and clears its sent flag. The reject on its own offers nothing.
- R8: A resend request offers every level source that meets the rule in R6. For each message source with rejected set, it clears rejected, and offers the source again only if it is unmasked.
- R9: An end-of-interrupt clears sent for a level source and offers nothing on its own. For a message source it has no effect.
- R10: Command op 2 (off) sets the priority to 0xFF and saves the old priority. Command op 3 (on) restores the priority from the saved value.
- R11: At most one source is handed over per clock, lowest source index first. While `pres_valid` is high and `pres_ready` is low, the offered source number holds.
- R12: The type bit in a write (`cmd_level`) takes effect only when the source was masked before that write.
- R13: Every command gets exactly one response, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Source inputs (edge for message, level for level type) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 write, 1 read, 2 off, 3 on |
| cmd_src | input | SRC_W | Global source number |
| cmd_server | input | SRV_W | Server for a write |
| cmd_prio | input | 9 | Priority for a write (values above 0xFF are refused) |
| cmd_level | input | 1 | Type for a write, 1 = level |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Parameter error |
| rsp_server | output | SRV_W | Server held before the command |
| rsp_prio | output | 8 | Priority held before the command |
| rsp_level | output | 1 | Type held before the command |
| pres_valid | output | 1 | Presentation offer valid |
| pres_ready | input | 1 | Presentation controller accepts the offer |
| pres_src | output | SRC_W | Global number of the offered source |
| pres_server | output | SRV_W | Destination server |
| pres_prio | output | 8 | Priority of the offer |
| rej_valid | input | 1 | Reject notification strobe |
| rej_src | input | SRC_W | Rejected source number |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_src | input | SRC_W | Source number for the end-of-interrupt |
| resend_req | input | 1 | Request to re-offer eligible sources |

## Verification
The bench builds the block with its default parameters: eight sources starting at global number 16, and four servers. With eight sources, every source number from 0 to 31 can be swept, so both edges of the window are exercised, and every source's configuration can be read back in full. Sources 0 to 3 are set up as message type and 4 to 7 as level type. That makes it practical to drive each ordering of reject, resend, end-of-interrupt and off/on on both types, and to pulse three message sources at once to check the handover order.

// File: rtl/irq_source_ctl.sv
module irq_source_ctl #(
  parameter int NUM_SRC     = 8,
  parameter int SRC_BASE    = 16,
  parameter int NUM_SERVERS = 4,
  parameter int SRC_W       = 16,
  parameter int SRV_W       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [SRC_W-1:0]   cmd_src,
  input  logic [SRV_W-1:0]   cmd_server,
  input  logic [8:0]         cmd_prio,
  input  logic               cmd_level,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [SRV_W-1:0]   rsp_server,
  output logic [7:0]         rsp_prio,
  output logic               rsp_level,
  output logic               pres_valid,
  input  logic               pres_ready,
  output logic [SRC_W-1:0]   pres_src,
  output logic [SRV_W-1:0]   pres_server,
  output logic [7:0]         pres_prio,
  input  logic               rej_valid,
  input  logic [SRC_W-1:0]   rej_src,
  input  logic               eoi_valid,
  input  logic [SRC_W-1:0]   eoi_src,
  input  logic               resend_req
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [7:0] OFF = 8'hFF;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_OFF = 2'd2, OP_ON = 2'd3;

  function automatic logic in_win(input logic [SRC_W-1:0] n);
    return (32'(n) >= SRC_BASE) && (32'(n) < SRC_BASE + NUM_SRC);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [SRC_W-1:0] n);
    logic [SRC_W-1:0] d;
    d = n - SRC_W'(SRC_BASE);
    return d[IDX_W-1:0];
  endfunction

  logic [7:0]       prio_q [NUM_SRC], prio_d [NUM_SRC];
  logic [7:0]       save_q [NUM_SRC], save_d [NUM_SRC];
  logic [SRV_W-1:0] srv_q  [NUM_SRC], srv_d  [NUM_SRC];
  logic [NUM_SRC-1:0] lvl_q, lsi_q, lsi_d, sent_q, sent_d, rej_q, rej_d, mp_q, mp_d, req_q, req_d;
  logic [NUM_SRC-1:0] cand;
  logic [IDX_W-1:0] first, win, lock_idx;
  logic             lock_q;

  wire [IDX_W-1:0] c_idx = to_idx(cmd_src);
  wire [IDX_W-1:0] r_idx = to_idx(rej_src);
  wire [IDX_W-1:0] e_idx = to_idx(eoi_src);
  wire cmd_ok = in_win(cmd_src) &&
                (cmd_op != OP_WR || (32'(cmd_server) < NUM_SERVERS && !cmd_prio[8]));
  wire fire = pres_valid && pres_ready;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      logic hit, cfg;
      prio_d[i] = prio_q[i]; save_d[i] = save_q[i]; srv_d[i] = srv_q[i];
      lsi_d[i] = lsi_q[i]; sent_d[i] = sent_q[i]; rej_d[i] = rej_q[i];
      mp_d[i] = mp_q[i]; req_d[i] = req_q[i];
      hit = cmd_valid && cmd_ok && c_idx == IDX_W'(i);
      cfg = hit && cmd_op != OP_RD;
      if (hit) begin
        case (cmd_op)
          OP_WR: begin
            prio_d[i] = cmd_prio[7:0]; save_d[i] = cmd_prio[7:0]; srv_d[i] = cmd_server;
            if (prio_q[i] == OFF) lsi_d[i] = cmd_level;
          end
          OP_OFF: begin save_d[i] = prio_q[i]; prio_d[i] = OFF; end
          OP_ON:  prio_d[i] = save_q[i];
          default: ;
        endcase
      end
      if (fire && win == IDX_W'(i)) begin
        req_d[i] = 1'b0;
        if (lsi_q[i]) sent_d[i] = 1'b1;
      end
      if (rej_valid && in_win(rej_src) && r_idx == IDX_W'(i)) begin
        rej_d[i] = 1'b1; sent_d[i] = 1'b0;
      end
      if (eoi_valid && in_win(eoi_src) && e_idx == IDX_W'(i) && lsi_q[i]) sent_d[i] = 1'b0;
      if (lsi_d[i]) begin
        if ((src_in[i] != lvl_q[i] || cfg || resend_req) &&
            prio_d[i] != OFF && src_in[i] && !sent_d[i]) req_d[i] = 1'b1;
      end else begin
        if (src_in[i] && !lvl_q[i]) begin
          if (prio_d[i] == OFF) mp_d[i] = 1'b1;
          else req_d[i] = 1'b1;
        end
        if (resend_req && rej_d[i]) begin
          rej_d[i] = 1'b0;
          if (prio_d[i] != OFF) req_d[i] = 1'b1;
        end
        if (cfg && mp_d[i] && prio_d[i] != OFF) begin
          mp_d[i] = 1'b0; req_d[i] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    first = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      cand[i] = req_q[i] && prio_q[i] != OFF;
      if (cand[i]) first = IDX_W'(i);
    end
  end

  assign win         = (lock_q && cand[lock_idx]) ? lock_idx : first;
  assign pres_valid  = |cand;
  assign pres_src    = SRC_W'(SRC_BASE) + SRC_W'(win);
  assign pres_server = srv_q[win];
  assign pres_prio   = prio_q[win];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        prio_q[i] <= OFF; save_q[i] <= OFF; srv_q[i] <= '0;
      end
      {lvl_q, lsi_q, sent_q, rej_q, mp_q, req_q} <= '0;
      lock_q <= 1'b0; lock_idx <= '0;
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_server <= '0; rsp_prio <= '0; rsp_level <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        prio_q[i] <= prio_d[i]; save_q[i] <= save_d[i]; srv_q[i] <= srv_d[i];
      end
      lvl_q <= src_in; lsi_q <= lsi_d; sent_q <= sent_d;
      rej_q <= rej_d; mp_q <= mp_d; req_q <= req_d;
      lock_q <= pres_valid && !pres_ready;
      lock_idx <= win;
      rsp_valid  <= cmd_valid;
      rsp_err    <= cmd_valid && !cmd_ok;
      rsp_server <= srv_q[c_idx];
      rsp_prio   <= prio_q[c_idx];
      rsp_level  <= lsi_q[c_idx];
    end
  end
endmodule

// File: rtl/irq_source_ctl_chk.sv
module irq_source_ctl_chk #(
  parameter int NUM_SRC  = 8,
  parameter int SRC_BASE = 16,
  parameter int SRC_W    = 16,
  parameter int SRV_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [SRC_W-1:0] cmd_src,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             pres_valid,
  input logic             pres_ready,
  input logic [SRC_W-1:0] pres_src,
  input logic [7:0]       pres_prio
);
  assert_resp_follows_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  assert_no_spurious_resp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
  assert_low_number_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && 32'(cmd_src) < SRC_BASE) |=> rsp_err);
  assert_never_offer_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> pres_prio != 8'hFF);
  assert_offer_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_valid && !pres_ready) |=> (!pres_valid || $stable(pres_src)));
  assert_offer_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> (32'(pres_src) >= SRC_BASE && 32'(pres_src) < SRC_BASE + NUM_SRC));
endmodule

bind irq_source_ctl irq_source_ctl_chk #(
  .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .SRC_W(SRC_W), .SRV_W(SRV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .pres_valid(pres_valid),
  .pres_ready(pres_ready), .pres_src(pres_src), .pres_prio(pres_prio)
);

// File: tb/irq_source_ctl_bench.sv
module irq_source_ctl_bench;
  localparam int N = 8, BASE = 16, NSRV = 4;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_in = '0;
  logic cmd_valid = 0, cmd_level = 0, pres_ready = 0, rej_valid = 0, eoi_valid = 0, resend_req = 0;
  logic [1:0] cmd_op = 0;
  logic [15:0] cmd_src = 0, rej_src = 0, eoi_src = 0, pres_src;
  logic [7:0] cmd_server = 0, rsp_server, pres_server, rsp_prio, pres_prio;
  logic [8:0] cmd_prio = 0;
  logic rsp_valid, rsp_err, rsp_level, pres_valid;
  int tests = 0, fails = 0;

  irq_source_ctl u_irq_source_ctl (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input int src, input int srv, input int pr, input bit lv);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_src = src[15:0]; cmd_server = srv[7:0];
    cmd_prio = pr[8:0]; cmd_level = lv;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic rd(input string tag, input int src, input int srv, input int pr, input bit lv);
    cmd(2'd1, src, 0, 0, 0);
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " err"}, rsp_err, 0);
    chk({tag, " server"}, rsp_server, srv);
    chk({tag, " prio"}, rsp_prio, pr);
    chk({tag, " level"}, rsp_level, lv);
  endtask

  task automatic take(input string tag, input int src, input int srv, input int pr);
    chk({tag, " valid"}, pres_valid, 1);
    chk({tag, " src"}, pres_src, src);
    chk({tag, " server"}, pres_server, srv);
    chk({tag, " prio"}, pres_prio, pr);
    pres_ready = 1;
    @(negedge clk);
    pres_ready = 0;
  endtask

  task automatic idle(input string tag);
    chk({tag, " idle"}, pres_valid, 0);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); src_in = src_in | m;
    @(negedge clk); src_in = src_in & ~m;
  endtask

  task automatic level(input int i, input bit v);
    @(negedge clk); src_in[i] = v;
    @(negedge clk);
  endtask

  task automatic note(input int kind, input int src);
    @(negedge clk);
    case (kind)
      0: begin rej_valid = 1; rej_src = src[15:0]; end
      1: begin eoi_valid = 1; eoi_src = src[15:0]; end
      default: resend_req = 1;
    endcase
    @(negedge clk);
    rej_valid = 0; eoi_valid = 0; resend_req = 0;
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #800000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1 after reset");
    for (int i = 0; i < N; i++) rd("R1 reset read", BASE + i, 0, 8'hFF, 0);

    for (int n = 0; n < 32; n++) begin
      cmd(2'd1, n, 0, 0, 0);
      chk("R3 window", rsp_err, (n < BASE || n >= BASE + N) ? 1 : 0);
    end
    cmd(2'd0, BASE, NSRV, 8'h20, 0);  chk("R3 server too big", rsp_err, 1);
    cmd(2'd0, BASE, 1, 9'h100, 0);    chk("R3 prio too big", rsp_err, 1);
    cmd(2'd2, BASE + N, 0, 0, 0);     chk("R3 off out of window", rsp_err, 1);
    rd("R3 unchanged", BASE, 0, 8'hFF, 0);

    for (int i = 0; i < N; i++) begin
      cmd(2'd0, BASE + i, i % NSRV, 8'h10 + i, i >= 4);
      chk("R2 write ok", rsp_err, 0);
    end
    for (int i = 0; i < N; i++) rd("R2 R12 readback", BASE + i, i % NSRV, 8'h10 + i, i >= 4);
    cmd(2'd0, BASE, 0, 8'h10, 1);
    rd("R12 type locked while unmasked", BASE, 0, 8'h10, 0);
    idle("R2 config offers nothing");

    pulse(8'h01);
    take("R4 message", BASE, 0, 8'h10);
    idle("R4 one offer");

    pulse(8'h0E);
    repeat (3) begin
      @(negedge clk);
      chk("R11 hold src", pres_src, BASE + 1);
    end
    take("R11 first", BASE + 1, 1, 8'h11);
    take("R11 second", BASE + 2, 2, 8'h12);
    take("R11 third", BASE + 3, 3, 8'h13);
    idle("R11 drained");

    cmd(2'd2, BASE + 1, 0, 0, 0);
    rd("R10 off masks", BASE + 1, 1, 8'hFF, 0);
    pulse(8'h02);
    idle("R5 masked edge");
    cmd(2'd3, BASE + 1, 0, 0, 0);
    take("R5 R10 on presents pending", BASE + 1, 1, 8'h11);
    idle("R5 once");
    rd("R10 on restores", BASE + 1, 1, 8'h11, 0);

    level(4, 1);
    take("R6 level", BASE + 4, 0, 8'h14);
    repeat (2) @(negedge clk);
    idle("R6 sent blocks");
    note(1, BASE + 4);
    idle("R9 eoi alone");
    note(2, 0);
    take("R6 R8 resend level", BASE + 4, 0, 8'h14);
    note(0, BASE + 4);
    idle("R7 reject alone");
    note(2, 0);
    take("R7 R8 resend after reject", BASE + 4, 0, 8'h14);
    level(4, 0);
    note(0, BASE + 4);
    note(2, 0);
    idle("R6 deasserted");

    pulse(8'h04);
    take("R4 message 2", BASE + 2, 2, 8'h12);
    note(0, BASE + 2);
    idle("R7 message reject");
    note(2, 0);
    take("R8 message resend", BASE + 2, 2, 8'h12);
    note(2, 0);
    idle("R8 rejected cleared");
    note(0, BASE + 2);
    cmd(2'd2, BASE + 2, 0, 0, 0);
    note(2, 0);
    idle("R8 masked rejected");
    cmd(2'd3, BASE + 2, 0, 0, 0);
    idle("R8 no pending after on");
    note(1, BASE + 2);
    idle("R9 message eoi");

    cmd(2'd2, BASE + 5, 0, 0, 0);
    level(5, 1);
    idle("R6 masked level");
    cmd(2'd3, BASE + 5, 0, 0, 0);
    take("R6 R10 on presents level", BASE + 5, 1, 8'h15);
    idle("R6 end");

    finish_run();
  end
endmodule